// File: doc/BRIEF.md
# Supervisory Reset Generator with Line-Activity Watchdog

This block produces the system reset for a microcontroller. It watches three sources. The first is a digital flag from an external comparator that reports the supply below its threshold. The second is a monitored serial data line. The third is the pair of reset pins, which are open-drain and are read back as level-sensitive requests. It drives two open-drain drive enables. One pulls the active-low reset pin low. The other pulls the active-high reset pin high.

A short dip flag is filtered out. A dip that lasts long enough holds reset for as long as the flag stays set. When the supply recovers, the hold timer runs for a fixed interval before the drivers let go. A request seen on either reset pin starts the same interval. The watchdog counts the cycles in which the data line does not change. When that count reaches its limit, the watchdog starts a reset. All times are counted in system clock ticks. The watchdog can be removed with a parameter.

Top module: `supv_reset_ctrl`

## Requirements
- R1: While the filtered below-threshold flag is set, both drive enables (`rst_lo_drv_o`, `rst_hi_drv_o`; 1 = driving the pin to its active level) stay at 1.
- R2: When the below flag input returns to 0, both enables stay at 1 until exactly HOLD_TICKS+3 cycles after the input change, then go to 0.
- R3: After the synchronous reset, both enables are 1 and stay 1 for HOLD_TICKS cycles after the last cycle in which reset was sampled high.
- R4: A below flag that is high for fewer than GLITCH_TICKS consecutive cycles has no effect. One that is high for GLITCH_TICKS cycles asserts the enables GLITCH_TICKS+3 cycles after it rises.
- R5: A 0 on `rst_lo_pin_i` or a 1 on `rst_hi_pin_i` while the block is not driving asserts both enables 3 cycles later. The reset is then held for HOLD_TICKS cycles.
- R6: The block's own drive, seen on the pin readback, never restarts the timeout. The enables stay 0 after a release.
- R7: If `sda_i` has not changed for WDOG_TICKS cycles, both enables go to 1 WDOG_TICKS+4 cycles after the last change. The full hold interval follows.
- R8: A rising or a falling change of `sda_i` restarts the watchdog count.
- R9: While reset is driven, the watchdog is held at zero. A later timeout counts from the release.
- R10: A below-flag event that arrives during an active hold restarts the hold count from zero.
- R11: With WDOG_EN = 0, inactivity on `sda_i` never asserts the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| below_i | input | 1 | Comparator flag, 1 = supply below threshold |
| sda_i | input | 1 | Monitored serial data line |
| rst_lo_pin_i | input | 1 | Readback of the active-low reset pin |
| rst_hi_pin_i | input | 1 | Readback of the active-high reset pin |
| rst_lo_drv_o | output | 1 | 1 = pull the active-low reset pin low |
| rst_hi_drv_o | output | 1 | 1 = pull the active-high reset pin high |

## Verification
Every input passes through a two-stage synchronizer, so each result is due a fixed number of cycles after the input changes:
- a qualified supply dip asserts reset GLITCH_TICKS+3 cycles after it starts;
- a pin request asserts reset after 3 cycles;
- supply recovery releases reset after HOLD_TICKS+3 cycles;
- line silence causes a timeout WDOG_TICKS+4 cycles after the last change.

The stimulus tasks change inputs on the falling clock edge. Each task queues the expected level of both enables for the exact cycle before and the exact cycle of every predicted change. A monitor compares the enables on the falling edge of the due cycle, so an output that changes one cycle early or late is caught.

// File: rtl/supv_pkg.sv
package supv_pkg;

    typedef enum logic {
        PH_RUN  = 1'b0,
        PH_HOLD = 1'b1
    } phase_e;

    typedef struct packed {
        logic below;
        logic sda;
        logic pin_lo;
        logic pin_hi;
    } sense_t;

    localparam int SENSE_W = $bits(sense_t);

    localparam sense_t SENSE_IDLE = '{below: 1'b0, sda: 1'b0, pin_lo: 1'b1, pin_hi: 1'b0};

    // width of a counter that must hold the values 0 .. n-1
    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
    parameter int             W       = 4,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/supv_glitch.sv
module supv_glitch #(
    parameter int GLITCH_TICKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic s,
    output logic flt
);
    import supv_pkg::*;
    localparam int CW = cnt_width(GLITCH_TICKS);
    localparam logic [CW-1:0] LAST = CW'(GLITCH_TICKS - 1);

    logic [CW-1:0] run;

    always_ff @(posedge clk) begin
        if (rst || !s) begin
            run <= '0;
            flt <= 1'b0;
        end else if (run == LAST) begin
            flt <= 1'b1;
        end else begin
            run <= run + 1'b1;
        end
    end

    // R4
    rise_needs_high_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flt) |-> $past(s));
endmodule

// File: rtl/supv_watchdog.sv
module supv_watchdog #(
    parameter int WDOG_TICKS = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic sda,
    input  logic hold,
    output logic bite
);
    import supv_pkg::*;
    localparam int CW = cnt_width(WDOG_TICKS);
    localparam logic [CW-1:0] LAST = CW'(WDOG_TICKS - 1);

    logic          prev;
    logic          primed;
    logic [CW-1:0] idle;
    logic          toggled;

    assign toggled = primed && (sda != prev);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev   <= 1'b0;
            primed <= 1'b0;
            idle   <= '0;
            bite   <= 1'b0;
        end else begin
            prev   <= sda;
            primed <= 1'b1;
            bite   <= 1'b0;
            if (hold || toggled) begin
                idle <= '0;
            end else if (idle == LAST) begin
                idle <= '0;
                bite <= 1'b1;
            end else begin
                idle <= idle + 1'b1;
            end
        end
    end

    // R9
    hold_clears_chk: assert property (@(posedge clk) disable iff (rst)
        hold |=> (idle == '0) && !bite);
    // R8
    toggle_restarts_chk: assert property (@(posedge clk) disable iff (rst)
        toggled |=> (idle == '0));
    // R7
    bite_single_chk: assert property (@(posedge clk) disable iff (rst)
        bite |=> !bite);
endmodule

// File: rtl/supv_timeout.sv
module supv_timeout #(
    parameter int HOLD_TICKS = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic active
);
    import supv_pkg::*;
    localparam int CW = cnt_width(HOLD_TICKS);
    localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

    phase_e        phase;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase <= PH_HOLD;
            cnt   <= '0;
        end else if (phase == PH_HOLD) begin
            if (cnt == LAST) begin
                phase <= PH_RUN;
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign active = (phase == PH_HOLD);

    // R2
    full_count_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(active) |-> ($past(cnt) == LAST));
    // R10
    restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> active && (cnt == '0));
endmodule

// File: rtl/supv_reset_ctrl.sv
module supv_reset_ctrl #(
    parameter int GLITCH_TICKS = 5,
    parameter int HOLD_TICKS   = 10_000_000,
    parameter int WDOG_TICKS   = 80_000_000,
    parameter bit WDOG_EN      = 1'b1,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic below_i,
    input  logic sda_i,
    input  logic rst_lo_pin_i,
    input  logic rst_hi_pin_i,
    output logic rst_lo_drv_o,
    output logic rst_hi_drv_o
);
    import supv_pkg::*;
    localparam int BLANK = SYNC_STAGES + 1;
    localparam int BW    = cnt_width(BLANK + 1);

    sense_t raw, sensed;
    logic   flt, bite, active, restart, ext_req, pins_quiet;
    logic [BW-1:0] blank;

    assign raw = '{below: below_i, sda: sda_i, pin_lo: rst_lo_pin_i, pin_hi: rst_hi_pin_i};

    supv_sync #(.W(SENSE_W), .STAGES(SYNC_STAGES), .RST_VAL(SENSE_IDLE)) sync_i (
        .clk(clk), .rst(rst), .d(raw), .q(sensed)
    );

    supv_glitch #(.GLITCH_TICKS(GLITCH_TICKS)) glitch_i (
        .clk(clk), .rst(rst), .s(sensed.below), .flt(flt)
    );

    generate
        if (WDOG_EN) begin : g_wdog
            supv_watchdog #(.WDOG_TICKS(WDOG_TICKS)) wdog_i (
                .clk(clk), .rst(rst), .sda(sensed.sda), .hold(active), .bite(bite)
            );
        end else begin : g_no_wdog
            assign bite = 1'b0;
        end
    endgenerate

    // readback blanking: covers the drive period plus the synchronizer latency
    always_ff @(posedge clk) begin
        if (rst || active)    blank <= BW'(BLANK);
        else if (blank != '0) blank <= blank - 1'b1;
    end

    assign pins_quiet = !active && (blank == '0);
    assign ext_req    = pins_quiet && (!sensed.pin_lo || sensed.pin_hi);
    assign restart    = flt || ext_req || bite;

    supv_timeout #(.HOLD_TICKS(HOLD_TICKS)) tmo_i (
        .clk(clk), .rst(rst), .restart(restart), .active(active)
    );

    assign rst_lo_drv_o = active;
    assign rst_hi_drv_o = active;

    // R1
    below_forces_chk: assert property (@(posedge clk) disable iff (rst)
        flt |=> active);
    // R7
    bite_forces_chk: assert property (@(posedge clk) disable iff (rst)
        bite |=> active);
    // R6
    no_self_retrigger_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(active) |=> !ext_req);
endmodule

// File: tb/supv_reset_ctrl_tb_top.sv
module supv_reset_ctrl_tb_top;
    localparam int G = 4;
    localparam int H = 20;
    localparam int W = 50;

    typedef struct {
        int    due;
        bit    act;
        bit    which;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic below = 1'b0;
    logic sda = 1'b1;
    logic ext_lo = 1'b1;
    logic ext_hi = 1'b0;
    logic kick_en = 1'b1;
    int   cyc = 0;
    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;
    exp_t q[$];

    logic lo_drv, hi_drv, lo_pin, hi_pin;
    logic nw_lo_drv, nw_hi_drv, nw_lo_pin, nw_hi_pin;

    assign lo_pin    = lo_drv    ? 1'b0 : ext_lo;
    assign hi_pin    = hi_drv    ? 1'b1 : ext_hi;
    assign nw_lo_pin = nw_lo_drv ? 1'b0 : ext_lo;
    assign nw_hi_pin = nw_hi_drv ? 1'b1 : ext_hi;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    supv_reset_ctrl #(.GLITCH_TICKS(G), .HOLD_TICKS(H), .WDOG_TICKS(W), .WDOG_EN(1'b1), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst), .below_i(below), .sda_i(sda),
        .rst_lo_pin_i(lo_pin), .rst_hi_pin_i(hi_pin),
        .rst_lo_drv_o(lo_drv), .rst_hi_drv_o(hi_drv)
    );

    supv_reset_ctrl #(.GLITCH_TICKS(G), .HOLD_TICKS(H), .WDOG_TICKS(W), .WDOG_EN(1'b0), .SYNC_STAGES(2)) nowd_i (
        .clk(clk), .rst(rst), .below_i(below), .sda_i(sda),
        .rst_lo_pin_i(nw_lo_pin), .rst_hi_pin_i(nw_hi_pin),
        .rst_lo_drv_o(nw_lo_drv), .rst_hi_drv_o(nw_hi_drv)
    );

    task automatic expect_at(input int off, input bit act, input bit which, input string tag);
        exp_t e;
        int   i = 0;
        e.due = cyc + off; e.act = act; e.which = which; e.tag = tag;
        while (i < q.size() && q[i].due <= e.due) i++;
        q.insert(i, e);
    endtask

    task automatic step();
        @(negedge clk);
        if (kick_en && (cyc % 8 == 0)) sda = ~sda;
    endtask

    task automatic wait_n(input int n);
        repeat (n) step();
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // monitor: compares queued expectations in their due cycle
    always @(negedge clk) begin : mon_blk
        exp_t e;
        logic a_lo, a_hi;
        while (q.size() > 0 && q[0].due <= cyc) begin
            e = q.pop_front();
            a_lo = e.which ? nw_lo_drv : lo_drv;
            a_hi = e.which ? nw_hi_drv : hi_drv;
            checks++;
            if (e.due != cyc || a_lo !== e.act || a_hi !== e.act) begin
                failures++;
                $display("FAIL %s cyc=%0d due=%0d dut=%0d actual=%b/%b expected=%b",
                         e.tag, cyc, e.due, e.which, a_lo, a_hi, e.act);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired at cyc=%0d", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        // R3: reset state and power-up hold
        step();
        expect_at(1, 1'b1, 1'b0, "R3");
        expect_at(1, 1'b1, 1'b1, "R3");
        step(); step();
        rst = 1'b0;
        expect_at(H - 1, 1'b1, 1'b0, "R3");
        expect_at(H,     1'b0, 1'b0, "R3");
        expect_at(H,     1'b0, 1'b1, "R3");
        wait_n(25);

        // R4: dip one cycle too short
        step();
        below = 1'b1;
        expect_at(8,  1'b0, 1'b0, "R4");
        expect_at(30, 1'b0, 1'b0, "R4");
        wait_n(G - 1);
        below = 1'b0;
        wait_n(35);

        // R1 / R2 / R4 boundary: long dip
        step();
        below = 1'b1;
        expect_at(G + 2, 1'b0, 1'b0, "R4");
        expect_at(G + 3, 1'b1, 1'b0, "R4");
        expect_at(40,    1'b1, 1'b0, "R1");
        wait_n(40);
        step();
        below = 1'b0;
        expect_at(H + 2, 1'b1, 1'b0, "R2");
        expect_at(H + 3, 1'b0, 1'b0, "R2");
        wait_n(H + 10);

        // R5 / R6: active-low pin request
        step();
        ext_lo = 1'b0;
        expect_at(2,      1'b0, 1'b0, "R5");
        expect_at(3,      1'b1, 1'b0, "R5");
        expect_at(H + 2,  1'b1, 1'b0, "R5");
        expect_at(H + 3,  1'b0, 1'b0, "R5");
        expect_at(H + 13, 1'b0, 1'b0, "R6");
        wait_n(2);
        ext_lo = 1'b1;
        wait_n(H + 20);

        // R5 / R6: active-high pin request
        step();
        ext_hi = 1'b1;
        expect_at(2,      1'b0, 1'b0, "R5");
        expect_at(3,      1'b1, 1'b0, "R5");
        expect_at(H + 3,  1'b0, 1'b0, "R5");
        expect_at(H + 13, 1'b0, 1'b0, "R6");
        wait_n(2);
        ext_hi = 1'b0;
        wait_n(H + 20);

        // R10: supply dip during an active hold restarts it
        step();
        ext_lo = 1'b0;
        expect_at(3, 1'b1, 1'b0, "R10");
        wait_n(2);
        ext_lo = 1'b1;
        wait_n(8);
        below = 1'b1;
        expect_at(H - 7,     1'b1, 1'b0, "R10");
        expect_at(G + H + 2, 1'b1, 1'b0, "R10");
        expect_at(G + H + 3, 1'b0, 1'b0, "R10");
        wait_n(G);
        below = 1'b0;
        wait_n(G + H + 15);

        // R7 / R8 / R9 / R11: watchdog
        kick_en = 1'b0;
        step();
        sda = ~sda;
        expect_at(W + 4, 1'b0, 1'b0, "R8");
        wait_n(30);
        sda = ~sda;
        expect_at(W + 3,         1'b0, 1'b0, "R7");
        expect_at(W + 4,         1'b1, 1'b0, "R7");
        expect_at(W + 4,         1'b0, 1'b1, "R11");
        expect_at(W + H + 3,     1'b1, 1'b0, "R7");
        expect_at(W + H + 4,     1'b0, 1'b0, "R7");
        expect_at(2 * W + H + 4, 1'b0, 1'b0, "R9");
        expect_at(2 * W + H + 5, 1'b1, 1'b0, "R9");
        expect_at(2 * W + H + 5, 1'b0, 1'b1, "R11");
        wait_n(2 * W + H + 15);
        kick_en = 1'b1;
        wait_n(4);

        if (q.size() != 0) begin
            failures++;
            $display("FAIL pending expectations left=%0d", q.size());
        end
        done = 1'b1;
        summary();
        $finish;
    end
endmodule